// File: doc/BRIEF.md
# SGRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics DRAM and walks the memory from power-on to a usable state. After a synchronous reset it holds the command bus idle while it counts out a startup pause of a configurable number of microseconds. Throughout that pause it keeps clock-enable and the byte masks high, so the data bus stays quiet. It then closes both banks with one precharge-all command. Next it loads the mode register and issues a configurable number of auto-refresh commands, in an order chosen by a parameter. Each command is followed by a fixed count of idle cycles that covers the memory's recovery time.

When the last wait has elapsed, a completion flag rises and stays high, and the byte masks are released. A memory controller holds its normal scheduler off until that flag is seen. A reset at any time aborts the sequence and starts it again from the pause.

Top module: `sgramInitSeq`

## Requirements
- R1: In every cycle that follows a clock edge at which `rst` is high, the bus shows NOP (`csN`,`rasN`,`casN`,`weN`,`dsf` = 0,1,1,1,0), `addr` and `ba` are zero, `cke` and `dqm` are 1 and `initDone` is 0.
- R2: The first cycle after the last reset edge is index 0. NOP is shown for indices 0 to PAUSE_US*CLK_MHZ inclusive.
- R3: At index PAUSE_US*CLK_MHZ+1 a single precharge-all cycle is shown: pins 0,0,1,0,0, bit PALL_BIT of `addr` set and every other bit zero, and `ba`=0.
- R4: Exactly TRP_CYC NOP cycles follow the precharge-all.
- R5: With REFRESH_FIRST=0, the precharge wait is followed by one mode-load cycle (pins 0,0,0,0,0) with `addr` equal to MODE_VAL, including its top bit.
- R6: Exactly MRD_CYC (at least 2) NOP cycles follow every mode-load.
- R7: REF_COUNT auto-refresh cycles (pins 0,0,0,1,0, `addr`=0) are issued, and each one is followed by exactly TRFC_CYC NOP cycles.
- R8: With REFRESH_FIRST=1, the refreshes come straight after the precharge wait, and the mode-load comes after the last refresh wait.
- R9: `initDone` rises in the cycle right after the final wait. From then on it stays high and the bus shows NOP.
- R10: `cke` is 1 in every cycle, and `dqm` is 1 exactly while `initDone` is 0.
- R11: A reset raised partway through the sequence restarts it, so the sequence after release matches R2 to R9 from index 0.
- R12: During every NOP cycle, `addr` and `ba` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| dsf | output | 1 | Special-function select (low for every command issued here) |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Byte mask, held high until done |
| addr | output | ADDR_W | Address bus (mode value or precharge-all bit) |
| ba | output | 1 | Bank select |
| initDone | output | 1 | Sequence complete, sticky |

## Verification
All bus outputs come from registers. A command shows in the cycle after the control state that asks for it, and the flag shows one cycle after the final wait ends, which makes every result due at a fixed index counted from the first cycle after the last reset edge. The bench keeps its own reference that maps each such index to the expected command, address and flag, using only the parameter arithmetic in the requirements. It samples on the falling clock edge and compares every cycle of two instances, one per ordering. For the reset state, the bench uses the reset level captured at the preceding rising edge, so a reset raised mid-sequence resets the index exactly when the design does.

// File: rtl/sgramInitPkg.sv
package sgramInitPkg;

  typedef enum logic [1:0] {
    CMD_NOP      = 2'd0,
    CMD_PREALL   = 2'd1,
    CMD_LOADMODE = 2'd2,
    CMD_REFRESH  = 2'd3
  } initCmd_t;

  typedef enum logic [1:0] {
    WSEL_PRE  = 2'd0,
    WSEL_MODE = 2'd1,
    WSEL_REF  = 2'd2
  } waitSel_t;

  typedef struct packed {
    logic     issuePre;
    logic     issueMode;
    logic     issueRef;
    logic     loadWait;
    waitSel_t waitSel;
    logic     finish;
  } ctrlStb_t;

  // Pin order {csN, rasN, casN, weN, dsf}
  function automatic logic [4:0] cmdPins(initCmd_t c);
    case (c)
      CMD_PREALL:   return 5'b00100;
      CMD_LOADMODE: return 5'b00000;
      CMD_REFRESH:  return 5'b00010;
      default:      return 5'b01110;
    endcase
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sgramInitCtrl.sv
module sgramInitCtrl
  import sgramInitPkg::*;
#(
  parameter bit REFRESH_FIRST = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     waitZero,
  input  logic     refsDone,
  output ctrlStb_t stb
);

  typedef enum logic [2:0] {
    S_PAUSE, S_PRE, S_WPRE, S_MODE, S_WMODE, S_REF, S_WREF, S_FIN
  } seqState_t;

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_PAUSE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.waitSel = WSEL_PRE;
    case (state)
      S_PAUSE: if (waitZero) stateNext = S_PRE;
      S_PRE: begin
        stb.issuePre = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = WSEL_PRE;
        stateNext    = S_WPRE;
      end
      S_WPRE: if (waitZero) stateNext = REFRESH_FIRST ? S_REF : S_MODE;
      S_MODE: begin
        stb.issueMode = 1'b1;
        stb.loadWait  = 1'b1;
        stb.waitSel   = WSEL_MODE;
        stateNext     = S_WMODE;
      end
      S_WMODE: if (waitZero) stateNext = REFRESH_FIRST ? S_FIN : S_REF;
      S_REF: begin
        stb.issueRef = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = WSEL_REF;
        stateNext    = S_WREF;
      end
      S_WREF: begin
        if (waitZero) begin
          if (refsDone) stateNext = REFRESH_FIRST ? S_MODE : S_FIN;
          else          stateNext = S_REF;
        end
      end
      S_FIN: stb.finish = 1'b1;
      default: stateNext = S_PAUSE;
    endcase
  end

  // R4
  issue_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.issuePre || stb.issueMode || stb.issueRef) |-> waitZero);

endmodule

// File: rtl/sgramInitDp.sv
module sgramInitDp
  import sgramInitPkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter int              CNT_W     = 16,
  parameter int              REF_W     = 4,
  parameter int              PAUSE_CYC = 40000,
  parameter int              TRP_CYC   = 3,
  parameter int              TRFC_CYC  = 14,
  parameter int              MRD_CYC   = 2,
  parameter int              REF_COUNT = 8,
  parameter int              PALL_BIT  = 8,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  output logic              waitZero,
  output logic              refsDone,
  output initCmd_t          cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              doneQ
);

  logic [CNT_W-1:0] waitCnt, loadVal;
  logic [REF_W-1:0] refLeft;

  assign waitZero = (waitCnt == '0);
  assign refsDone = (refLeft == '0);

  always_comb begin
    case (stb.waitSel)
      WSEL_MODE: loadVal = CNT_W'(MRD_CYC - 1);
      WSEL_REF:  loadVal = CNT_W'(TRFC_CYC - 1);
      default:   loadVal = CNT_W'(TRP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               waitCnt <= CNT_W'(PAUSE_CYC - 1);
    else if (stb.loadWait) waitCnt <= loadVal;
    else if (!waitZero)    waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               refLeft <= REF_W'(REF_COUNT);
    else if (stb.issueRef) refLeft <= refLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= doneQ | stb.finish;
      if (stb.issuePre) begin
        cmdQ  <= CMD_PREALL;
        addrQ <= ADDR_W'(1) << PALL_BIT;
      end else if (stb.issueMode) begin
        cmdQ  <= CMD_LOADMODE;
        addrQ <= MODE_VAL;
      end else if (stb.issueRef) begin
        cmdQ  <= CMD_REFRESH;
        addrQ <= '0;
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
      end
    end
  end

  // R7
  ref_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    stb.issueRef |-> !refsDone);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> doneQ);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> (cmdQ == CMD_NOP));

  // R6
  mode_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdQ == CMD_LOADMODE) |=> (cmdQ == CMD_NOP));

  // R12
  nop_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdQ == CMD_NOP) |-> (addrQ == '0));

endmodule

// File: rtl/sgramInitSeq.sv
module sgramInitSeq
  import sgramInitPkg::*;
#(
  parameter int              CLK_MHZ       = 200,
  parameter int              PAUSE_US      = 200,
  parameter int              TRP_CYC       = 3,
  parameter int              TRFC_CYC      = 14,
  parameter int              MRD_CYC       = 2,
  parameter int              REF_COUNT     = 8,
  parameter bit              REFRESH_FIRST = 1'b0,
  parameter int              ADDR_W        = 10,
  parameter int              PALL_BIT      = 8,
  parameter logic [ADDR_W-1:0] MODE_VAL    = 10'h032
) (
  input  logic              clk,
  input  logic              rst,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              dsf,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              ba,
  output logic              initDone
);

  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int MAX_WAIT  = maxOf(maxOf(PAUSE_CYC, TRP_CYC), maxOf(TRFC_CYC, MRD_CYC));
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);
  localparam int REF_W     = $clog2(REF_COUNT + 1);

  ctrlStb_t stb;
  logic     waitZero, refsDone, doneQ;
  initCmd_t cmdQ;

  sgramInitCtrl #(.REFRESH_FIRST(REFRESH_FIRST)) u_ctrl (
    .clk(clk), .rst(rst), .waitZero(waitZero), .refsDone(refsDone), .stb(stb)
  );

  sgramInitDp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REF_W(REF_W), .PAUSE_CYC(PAUSE_CYC),
    .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .MRD_CYC(MRD_CYC),
    .REF_COUNT(REF_COUNT), .PALL_BIT(PALL_BIT), .MODE_VAL(MODE_VAL)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .waitZero(waitZero), .refsDone(refsDone),
    .cmdQ(cmdQ), .addrQ(addr), .doneQ(doneQ)
  );

  assign {csN, rasN, casN, weN, dsf} = cmdPins(cmdQ);
  assign cke      = 1'b1;
  assign dqm      = ~doneQ;
  assign ba       = 1'b0;
  assign initDone = doneQ;

endmodule

// File: tb/sgramInitSeq_bench.sv
`timescale 1ns/1ps
module sgramInitSeq_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstA = 1'b1, rstB = 1'b1;
  logic rstSeenA = 1'b1, rstSeenB = 1'b1;
  bit   restartA = 1'b0, restartB = 1'b0;
  int   idxA = 0, idxB = 0;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  // instance A: default parameters, mode load first
  localparam int A_P = 200 * 200;
  logic [4:0] pinsA; logic [9:0] addrA; logic baA, ckeA, dqmA, doneA;
  sgramInitSeq u_sgramInitSeq (
    .clk(clk), .rst(rstA), .csN(pinsA[4]), .rasN(pinsA[3]), .casN(pinsA[2]),
    .weN(pinsA[1]), .dsf(pinsA[0]), .cke(ckeA), .dqm(dqmA), .addr(addrA),
    .ba(baA), .initDone(doneA)
  );

  // instance B: refresh first, short pause, other timings
  localparam int B_P = 1 * 200;
  logic [4:0] pinsB; logic [9:0] addrB; logic baB, ckeB, dqmB, doneB;
  sgramInitSeq #(
    .CLK_MHZ(200), .PAUSE_US(1), .TRP_CYC(2), .TRFC_CYC(5), .MRD_CYC(2),
    .REF_COUNT(3), .REFRESH_FIRST(1'b1), .PALL_BIT(8), .MODE_VAL(10'h2A7)
  ) u_sgramInitSeq_refFirst (
    .clk(clk), .rst(rstB), .csN(pinsB[4]), .rasN(pinsB[3]), .casN(pinsB[2]),
    .weN(pinsB[1]), .dsf(pinsB[0]), .cke(ckeB), .dqm(dqmB), .addr(addrB),
    .ba(baB), .initDone(doneB)
  );

  // 0 NOP, 1 precharge-all, 2 mode load, 3 refresh, 4 done (NOP)
  function automatic int expCode(int idx, int pCyc, int trp, int trfc, int mrd,
                                 int nref, bit refFirst, output string tag);
    int t;
    t = idx;
    if (t <= pCyc) begin tag = "R2"; return 0; end
    t -= pCyc + 1;
    if (t == 0) begin tag = "R3"; return 1; end
    t--;
    if (t < trp) begin tag = "R4"; return 0; end
    t -= trp;
    for (int ph = 0; ph < 2; ph++) begin
      if ((ph == 0) != refFirst) begin
        if (t == 0) begin tag = refFirst ? "R8" : "R5"; return 2; end
        t--;
        if (t < mrd) begin tag = "R6"; return 0; end
        t -= mrd;
      end else begin
        for (int k = 0; k < nref; k++) begin
          if (t == 0) begin tag = "R7"; return 3; end
          t--;
          if (t < trfc) begin tag = "R7"; return 0; end
          t -= trfc;
        end
      end
    end
    tag = "R9";
    return 4;
  endfunction

  task automatic checkVal(string who, string tag, int idx, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s idx=%0d actual=%h expected=%h", tag, who, idx, act, expv);
    end
  endtask

  task automatic checkCycle(string who, int idx, bit inRst, bit restarted,
                            int pCyc, int trp, int trfc, int mrd, int nref, bit refFirst,
                            logic [9:0] modeVal, int pallBit,
                            logic [4:0] pins, logic [9:0] addr, logic ba,
                            logic cke, logic dqm, logic done);
    string tag;
    int code;
    logic [4:0] ePins;
    logic [9:0] eAddr;
    code = expCode(idx, pCyc, trp, trfc, mrd, nref, refFirst, tag);
    case (code)
      1: begin ePins = 5'b00100; eAddr = 10'(1) << pallBit; end
      2: begin ePins = 5'b00000; eAddr = modeVal; end
      3: begin ePins = 5'b00010; eAddr = '0; end
      default: begin ePins = 5'b01110; eAddr = '0; end
    endcase
    if (inRst) tag = "R1";
    if (restarted) tag = {tag, " R11"};
    checkVal(who, (code == 0 || code == 4) ? {tag, " R12"} : tag, idx,
             {pins, addr, ba}, {ePins, eAddr, 1'b0});
    checkVal(who, (code == 4) ? {tag, " R10 R9"} : {tag, " R10"}, idx,
             {13'd0, cke, dqm, done}, {13'd0, 1'b1, code != 4, code == 4});
  endtask

  always @(posedge clk) begin
    rstSeenA <= rstA;
    rstSeenB <= rstB;
  end

  always @(negedge clk) begin
    int useIdx;
    if (!finished) begin
      if (rstSeenA) begin useIdx = 0; idxA = 1; end
      else begin useIdx = idxA; idxA++; end
      checkCycle("A", useIdx, rstSeenA, restartA, A_P, 3, 14, 2, 8, 1'b0, 10'h032, 8,
                 pinsA, addrA, baA, ckeA, dqmA, doneA);
      if (rstSeenB) begin useIdx = 0; idxB = 1; end
      else begin useIdx = idxB; idxB++; end
      checkCycle("B", useIdx, rstSeenB, restartB, B_P, 2, 5, 2, 3, 1'b1, 10'h2A7, 8,
                 pinsB, addrB, baB, ckeB, dqmB, doneB);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    rstA = 1'b0; rstB = 1'b0;
    step(210);                 // B is in its refresh phase
    rstB = 1'b1; restartB = 1'b1;
    step(2);
    rstB = 1'b0;
    step(40020 - 212);         // A is in its refresh phase
    rstA = 1'b1; restartA = 1'b1;
    step(3);
    rstA = 1'b0;
    step(40300);               // both complete and idle with done high
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule